// File: doc/BRIEF.md
# Indexed Chipset Configuration and Shadow-Memory Controller

This block sits on an 8-bit I/O bus inside a legacy PC chipset and answers a group of four consecutive I/O ports, selected upstream and presented here as a 2-bit offset. Offset 0 is a pointer register. Offset 1 is a data window into the configuration register file at the pointed-to location. Offset 2 is a gate-line control port: a write drops the address-line-20 gate and a read raises it. Offset 3 is a trigger port: a read of it requests a soft processor reset.

Six of the configuration registers form a shadow map over the upper-memory window, 0xA0000 to 0xFFFFF. The map is split into 16 KB segments, and each segment has a 2-bit routing code. A combinational decoder takes any memory address and reports whether a read from it and a write to it are served by internal DRAM or sent to the external bus. It also reports whether any BIOS-area segment, 0xE0000 and above, is shadowed for reads and whether any is shadowed for writes.

The reset request comes from a small state machine with three states. `RS_IDLE` waits for a trigger read and moves to `RS_FIRE` when one arrives. `RS_FIRE` drives the pulse for one clock, then moves to `RS_HOLD` if the read strobe is still held, or back to `RS_IDLE` if it is not. `RS_HOLD` waits for the strobe to drop and then returns to `RS_IDLE`.

Top module: `cfgport_shadow_ctl`

## Requirements
- R1: A write at offset 0 loads the 8-bit pointer, and a read at offset 0 returns the pointer's current value.
- R2: A write at offset 1 updates the pointed-to register only when the pointer is in 0x01..0x24 inclusive. With any other pointer value the write changes nothing.
- R3: A read at offset 1 returns the register at the pointer for every pointer value. Location 0x00 reads 0x90, and locations 0x25..0xFF read 0x00.
- R4: Bit 4 of register 0x05 cannot be written. It stays 0, while the other seven bits take the written value.
- R5: After reset, 0x00=0x90, 0x01=0xFF, 0x02=0x8A, 0x03=0x88, 0x06=0x1B and 0x08=0x38. Every other location is 0x00.
- R6: Register 0x0D+k (k=0..5) covers the four 16 KB segments that start at 0xA0000 + k×64 KB. The field at bits [2j+1:2j] controls the segment at offset j×16 KB within that range.
- R7: In a routing code, bit 1 set sends reads to internal memory and bit 0 set sends writes to internal memory. A clear bit sends that access to the external bus. An address below 0xA0000 reports both accesses as external.
- R8: The BIOS read-shadow flag is the OR of bit 1 of every field in registers 0x11 and 0x12. The BIOS write-shadow flag is the OR of bit 0 of those same fields.
- R9: The address-line-20 gate is 0 after reset. A write at offset 2 clears it from the next cycle, and a read at offset 2 sets it from the next cycle.
- R10: A read at offset 3 produces a reset pulse exactly one clock long, starting the cycle after the strobe is first sampled. A strobe held over several cycles produces only one pulse.
- R11: Reads at offsets 2 and 3 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_ofs | input | 2 | Port offset within the four-port group |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational on the offset) |
| mem_addr | input | 20 | Memory address being routed |
| mem_rd_int | output | 1 | Reads at mem_addr go to internal memory |
| mem_wr_int | output | 1 | Writes at mem_addr go to internal memory |
| bios_shd_rd | output | 1 | Some BIOS-area segment is read-shadowed |
| bios_shd_wr | output | 1 | Some BIOS-area segment is write-shadowed |
| a20_gate | output | 1 | Address-line-20 gate |
| cpu_rst_pulse | output | 1 | Soft processor reset request pulse |

## Verification
The properties assume that the read and write strobes are never high in the same cycle. The gate-port assertions rely on this, because the design only defines write-wins as a tie-break. The bench drives each access from a task that raises exactly one strobe for one cycle, or for a deliberately longer hold on the trigger port, so it never violates the assumption. Random pointer values are biased toward 0x00..0x2F so that both the writable range and its two edges are hit often. Random memory addresses span the whole 1 MB space, with the window boundaries also driven directly.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam int CFG_DW = 8;
    localparam int OFS_W  = 2;

    localparam logic [OFS_W-1:0] OFS_INDEX = 2'd0;
    localparam logic [OFS_W-1:0] OFS_DATA  = 2'd1;
    localparam logic [OFS_W-1:0] OFS_GATE  = 2'd2;
    localparam logic [OFS_W-1:0] OFS_RESET = 2'd3;

    localparam int SHD_RD_BIT = 1;
    localparam int SHD_WR_BIT = 0;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_FIRE = 2'd1,
        RS_HOLD = 2'd2
    } rst_state_e;

    function automatic logic [CFG_DW-1:0] cfg_rst_val(input int i);
        case (i)
            0:       return 8'h90;
            1:       return 8'hFF;
            2:       return 8'h8A;
            3:       return 8'h88;
            6:       return 8'h1B;
            8:       return 8'h38;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [CFG_DW-1:0] cfg_ro_mask(input int i);
        return (i == 5) ? 8'h10 : 8'h00;
    endfunction
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfgport_pkg::*;
#(
    parameter int IDX_LO = 1,
    parameter int IDX_HI = 36
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          idx_wr,
    input  logic                          data_wr,
    input  logic [CFG_DW-1:0]             wdata,
    output logic [CFG_DW-1:0]             idx_q,
    output logic [CFG_DW-1:0]             rdata,
    output logic [(IDX_HI+1)*CFG_DW-1:0]  rf_flat
);
    localparam int NREG = IDX_HI + 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= wdata;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [CFG_DW-1:0] RST = cfg_rst_val(g);
        localparam logic [CFG_DW-1:0] ROM = cfg_ro_mask(g);
        logic [CFG_DW-1:0] q;
        if (g < IDX_LO) begin : g_fixed
            assign q = RST;
        end else begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= RST;
                else if (data_wr && (idx_q == CFG_DW'(g)))
                    q <= (q & ROM) | (wdata & ~ROM);
            end
        end
        assign rf_flat[g*CFG_DW +: CFG_DW] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx_q == CFG_DW'(i)) rdata = rf_flat[i*CFG_DW +: CFG_DW];
        end
    end
endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
    import cfgport_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int SEG_SH    = 14,
    parameter int SHD_REGS  = 6,
    parameter int WIN_SEG0  = 40,
    parameter int BIOS_SEG0 = 16
) (
    input  logic [ADDR_W-1:0]          mem_addr,
    input  logic [SHD_REGS*CFG_DW-1:0] shd_bits,
    output logic                       mem_rd_int,
    output logic                       mem_wr_int,
    output logic                       bios_shd_rd,
    output logic                       bios_shd_wr
);
    localparam int SEGS  = SHD_REGS * (CFG_DW / 2);
    localparam int SEG_W = ADDR_W - SEG_SH;

    logic [SEG_W-1:0] seg_num;
    logic [SEG_W-1:0] seg_off;
    logic             in_win;
    logic [SEGS-1:0]  hit, rd_bits, wr_bits, bios_rd_m, bios_wr_m;

    assign seg_num = mem_addr[ADDR_W-1:SEG_SH];
    assign in_win  = seg_num >= SEG_W'(WIN_SEG0);
    assign seg_off = seg_num - SEG_W'(WIN_SEG0);

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        assign hit[s]     = in_win && (seg_off == SEG_W'(s));
        assign rd_bits[s] = shd_bits[2*s + SHD_RD_BIT];
        assign wr_bits[s] = shd_bits[2*s + SHD_WR_BIT];
        if (s >= BIOS_SEG0) begin : g_bios
            assign bios_rd_m[s] = rd_bits[s];
            assign bios_wr_m[s] = wr_bits[s];
        end else begin : g_low
            assign bios_rd_m[s] = 1'b0;
            assign bios_wr_m[s] = 1'b0;
        end
    end

    assign mem_rd_int  = |(hit & rd_bits);
    assign mem_wr_int  = |(hit & wr_bits);
    assign bios_shd_rd = |bios_rd_m;
    assign bios_shd_wr = |bios_wr_m;
endmodule

// File: rtl/softrst_fsm.sv
module softrst_fsm
    import cfgport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    rst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (trig)  state_d = RS_FIRE;
            RS_FIRE: state_d = trig ? RS_HOLD : RS_IDLE;
            RS_HOLD: if (!trig) state_d = RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        pulse = (state_q == RS_FIRE);
    end
endmodule

// File: rtl/cfgport_shadow_ctl.sv
module cfgport_shadow_ctl
    import cfgport_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int IDX_LO   = 1,
    parameter int IDX_HI   = 36,
    parameter int SHD_BASE = 13,
    parameter int SHD_REGS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  io_ofs,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [CFG_DW-1:0] io_wdata,
    output logic [CFG_DW-1:0] io_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_int,
    output logic              mem_wr_int,
    output logic              bios_shd_rd,
    output logic              bios_shd_wr,
    output logic              a20_gate,
    output logic              cpu_rst_pulse
);
    localparam int RF_W = (IDX_HI + 1) * CFG_DW;

    logic [CFG_DW-1:0] cur_idx, data_rd;
    logic [RF_W-1:0]   rf_flat;

    cfg_regfile #(.IDX_LO(IDX_LO), .IDX_HI(IDX_HI)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (io_wr && io_ofs == OFS_INDEX),
        .data_wr (io_wr && io_ofs == OFS_DATA),
        .wdata   (io_wdata),
        .idx_q   (cur_idx),
        .rdata   (data_rd),
        .rf_flat (rf_flat)
    );

    shadow_decode #(.ADDR_W(ADDR_W), .SHD_REGS(SHD_REGS)) u_shd (
        .mem_addr    (mem_addr),
        .shd_bits    (rf_flat[(SHD_BASE+SHD_REGS)*CFG_DW-1 : SHD_BASE*CFG_DW]),
        .mem_rd_int  (mem_rd_int),
        .mem_wr_int  (mem_wr_int),
        .bios_shd_rd (bios_shd_rd),
        .bios_shd_wr (bios_shd_wr)
    );

    softrst_fsm u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (io_rd && io_ofs == OFS_RESET),
        .pulse (cpu_rst_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           a20_gate <= 1'b0;
        else if (io_wr && io_ofs == OFS_GATE) a20_gate <= 1'b0;
        else if (io_rd && io_ofs == OFS_GATE) a20_gate <= 1'b1;
    end

    always_comb begin
        unique case (io_ofs)
            OFS_INDEX: io_rdata = cur_idx;
            OFS_DATA:  io_rdata = data_rd;
            default:   io_rdata = '1;
        endcase
    end
endmodule

// File: rtl/cfgport_shadow_chk.sv
module cfgport_shadow_chk
    import cfgport_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int IDX_HI = 36
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [OFS_W-1:0]             io_ofs,
    input logic                         io_wr,
    input logic                         io_rd,
    input logic [CFG_DW-1:0]            io_wdata,
    input logic [ADDR_W-1:0]            mem_addr,
    input logic                         mem_rd_int,
    input logic                         mem_wr_int,
    input logic                         a20_gate,
    input logic                         cpu_rst_pulse,
    input logic [CFG_DW-1:0]            cur_idx,
    input logic [(IDX_HI+1)*CFG_DW-1:0] rf_flat
);
    // R1
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_ofs == OFS_INDEX) |=> (cur_idx == $past(io_wdata)));

    // R2
    oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_ofs == OFS_DATA && (cur_idx == 8'h00 || cur_idx > CFG_DW'(IDX_HI)))
        |=> $stable(rf_flat));

    // R4
    ro_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_flat[5*CFG_DW + 4]);

    // R7
    below_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr < ADDR_W'(20'hA0000)) |-> (!mem_rd_int && !mem_wr_int));

    // R9
    gate_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_ofs == OFS_GATE) |=> !a20_gate);

    // R9
    gate_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_ofs == OFS_GATE) |=> a20_gate);

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_pulse |=> !cpu_rst_pulse);

    // R10
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_pulse) |-> $past(io_rd && io_ofs == OFS_RESET));
endmodule

bind cfgport_shadow_ctl cfgport_shadow_chk #(.ADDR_W(ADDR_W), .IDX_HI(IDX_HI)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_ofs        (io_ofs),
    .io_wr         (io_wr),
    .io_rd         (io_rd),
    .io_wdata      (io_wdata),
    .mem_addr      (mem_addr),
    .mem_rd_int    (mem_rd_int),
    .mem_wr_int    (mem_wr_int),
    .a20_gate      (a20_gate),
    .cpu_rst_pulse (cpu_rst_pulse),
    .cur_idx       (cur_idx),
    .rf_flat       (rf_flat)
);

// File: tb/cfgport_shadow_ctl_tb.sv
module cfgport_shadow_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  io_ofs = 2'd0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [19:0] mem_addr = 20'h0;
    logic        mem_rd_int, mem_wr_int, bios_shd_rd, bios_shd_wr, a20_gate, cpu_rst_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #10 clk = ~clk;

    cfgport_shadow_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .io_ofs(io_ofs), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
        .mem_rd_int(mem_rd_int), .mem_wr_int(mem_wr_int), .bios_shd_rd(bios_shd_rd),
        .bios_shd_wr(bios_shd_wr), .a20_gate(a20_gate), .cpu_rst_pulse(cpu_rst_pulse)
    );

    always @(negedge clk) if (rst_n && cpu_rst_pulse) pulses++;

    function automatic logic [7:0] rst_exp(input int i);
        case (i)
            0: return 8'h90;  1: return 8'hFF;  2: return 8'h8A;
            3: return 8'h88;  6: return 8'h1B;  8: return 8'h38;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [1:0] seg_code(input logic [19:0] a);
        int seg;
        if (a < 20'hA0000) return 2'b00;
        seg = int'((a - 20'hA0000) >> 14);
        return 2'((model[8'h0D + seg/4] >> (2*(seg%4))) & 8'h03);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [1:0] o, input logic [7:0] d);
        @(negedge clk);
        io_ofs = o; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [1:0] o, output logic [7:0] d);
        @(negedge clk);
        io_ofs = o; io_rd = 1'b1;
        #5 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic model_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(2'd0, idx);
        io_write(2'd1, d);
        if (idx >= 8'h01 && idx <= 8'h24) begin
            if (idx == 8'h05) model[idx] = (model[idx] & 8'h10) | (d & 8'hEF);
            else              model[idx] = d;
        end
    endtask

    task automatic check_addr(input logic [19:0] a);
        logic [1:0] c;
        @(negedge clk);
        mem_addr = a;
        #2 c = seg_code(a);
        chk("R6/R7 read route", {31'd0, mem_rd_int}, {31'd0, c[1]});
        chk("R6/R7 write route", {31'd0, mem_wr_int}, {31'd0, c[0]});
    endtask

    task automatic check_bios();
        logic erd, ewr;
        erd = |((model[8'h11] | model[8'h12]) & 8'hAA);
        ewr = |((model[8'h11] | model[8'h12]) & 8'h55);
        #2;
        chk("R8 bios read flag", {31'd0, bios_shd_rd}, {31'd0, erd});
        chk("R8 bios write flag", {31'd0, bios_shd_wr}, {31'd0, ewr});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] idx;
        int p0;
        void'($urandom(32'd20240));
        for (int i = 0; i < 256; i++) model[i] = rst_exp(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5 / R9 / R3 reset state
        chk("R9 gate after reset", {31'd0, a20_gate}, 32'd0);
        chk("R10 no pulse after reset", {31'd0, cpu_rst_pulse}, 32'd0);
        for (int i = 0; i < 48; i++) begin
            io_write(2'd0, 8'(i));
            io_read(2'd1, d);
            chk("R5 reset value", {24'd0, d}, {24'd0, rst_exp(i)});
        end
        io_write(2'd0, 8'hFF);
        io_read(2'd1, d);
        chk("R3 read at 0xFF", {24'd0, d}, 32'd0);
        check_bios();

        // R1 pointer read-back
        io_write(2'd0, 8'h5A);
        io_read(2'd0, d);
        chk("R1 pointer readback", {24'd0, d}, 32'h5A);

        // R2 edges of the writable range
        model_write(8'h00, 8'h11);
        io_read(2'd1, d);
        chk("R2 write at 0x00 ignored", {24'd0, d}, 32'h90);
        model_write(8'h25, 8'h77);
        io_read(2'd1, d);
        chk("R2 write at 0x25 ignored", {24'd0, d}, 32'h00);
        model_write(8'h24, 8'hC3);
        io_read(2'd1, d);
        chk("R2 write at 0x24 taken", {24'd0, d}, 32'hC3);
        model_write(8'h01, 8'h3C);
        io_read(2'd1, d);
        chk("R2 write at 0x01 taken", {24'd0, d}, 32'h3C);

        // R4 read-only bit
        model_write(8'h05, 8'hFF);
        io_read(2'd1, d);
        chk("R4 bit4 stays clear", {24'd0, d}, 32'hEF);

        // R11 side ports read 0xFF
        io_read(2'd3, d);
        chk("R11 trigger port data", {24'd0, d}, 32'hFF);
        io_read(2'd2, d);
        chk("R11 gate port data", {24'd0, d}, 32'hFF);

        // R9 gate set / clear
        chk("R9 gate set by read", {31'd0, a20_gate}, 32'd1);
        io_read(2'd2, d);
        chk("R9 gate stays set", {31'd0, a20_gate}, 32'd1);
        io_write(2'd2, 8'h00);
        chk("R9 gate cleared by write", {31'd0, a20_gate}, 32'd0);
        io_write(2'd2, 8'hFF);
        chk("R9 gate stays clear", {31'd0, a20_gate}, 32'd0);

        // R10 pulse timing and count
        @(negedge clk);
        io_ofs = 2'd3; io_rd = 1'b1;
        chk("R10 no pulse at strobe", {31'd0, cpu_rst_pulse}, 32'd0);
        @(negedge clk);
        chk("R10 pulse next cycle", {31'd0, cpu_rst_pulse}, 32'd1);
        repeat (4) @(negedge clk);
        io_rd = 1'b0;
        repeat (3) @(negedge clk);
        p0 = pulses;
        io_read(2'd3, d);
        io_read(2'd3, d);
        @(negedge clk);
        @(negedge clk);
        chk("R10 two reads two pulses", 32'(pulses - p0), 32'd2);
        chk("R10 held strobe total", 32'(pulses), 32'd4);

        // random register traffic
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 8) == 0) idx = 8'($urandom);
            else                     idx = 8'($urandom % 48);
            if (($urandom % 2) == 0) model_write(idx, 8'($urandom));
            else                     io_write(2'd0, idx);
            io_read(2'd0, d);
            chk("R1 pointer random", {24'd0, d}, {24'd0, idx});
            io_read(2'd1, d);
            chk("R2/R3 data random", {24'd0, d}, {24'd0, model[idx]});
        end

        // shadow map
        for (int r = 0; r < 6; r++) begin
            model_write(8'(8'h0D + r), 8'($urandom));
            check_bios();
            check_addr(20'hA0000 + 20'(r) * 20'h10000 + 20'h8000);
        end
        check_addr(20'h9FFFF);
        check_addr(20'hA0000);
        check_addr(20'hDFFFF);
        check_addr(20'hE0000);
        check_addr(20'hFFFFF);
        for (int n = 0; n < 200; n++) check_addr(20'($urandom));

        // R8 only the top two registers matter
        model_write(8'h11, 8'h00);
        model_write(8'h12, 8'h00);
        model_write(8'h10, 8'hFF);
        check_bios();
        model_write(8'h12, 8'h40);
        check_bios();
        model_write(8'h11, 8'h01);
        check_bios();
        for (int s = 0; s < 24; s++) check_addr(20'hA0000 + 20'(s) * 20'h4000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule